// File: doc/BRIEF.md
# Bus Transaction and Line-Reset Sequencer

This block runs whole transactions on a two-wire serial management link. It sits between a simple request port and two neighbouring engines: a frame transmitter, which serialises one command, and a response receiver, which captures one reply, checks its CRC and reports the reply's tag. The block tells the transmitter which kind of command to send (an access, a data poll or a terminate). It drives the line itself during the idle stretches between frames. It then turns the reply into a single status code and, for reads, returns the data.

When a slave replies BUSY, the block clocks an idle gap with the line high and sends a data-poll command. It repeats this up to a retry limit. Once the limit is used up, the next BUSY leads to a terminate command to the same slave. After every final reply it drives a run of idle clocks so the slave is ready for the next operation. A break request produces a fixed line-reset pattern. After reset the block flushes the link with a long run of idle clocks. Only one transaction is handled at a time.

Top module: `bus_txn_sequencer`

## Requirements
- R1: While reset is held, and for the INIT_CYC cycles after reset is released, `busy`, `ln_en` and `ln_dat` are all 1 and `stat_vld` is 0. `busy` then falls.
- R2: A read or write request on link 0 pulses `tx_go` with `tx_kind`=0 (access). The write flag, slave and address of the request appear on `tx_*`. After `tx_done` the block drives ECHO_CYC idle-high line cycles and then pulses `rx_go`. `rx_bytes` equals the request size for a read and 0 for a write. An ACK reply (`rx_tag`=0) without timeout or CRC error gives status 0 (OK), and for a read it returns `rx_data` on `rdata`.
- R3: A BUSY reply (`rx_tag`=1) to an access or poll is followed by an idle-high gap of max(POLL_IDLE,21) line cycles. A poll command (`tx_kind`=1), an echo run and a new `rx_go` follow the gap.
- R4: After BUSY_MAX polls, the next BUSY reply leads to the same gap and then a terminate command (`tx_kind`=2). An ACK reply to the terminate gives status 1 (stuck busy).
- R5: Any reply to the terminate other than a clean ACK gives the failure status of that reply, never status 1. A BUSY or error tag gives 2, a timeout gives 3 and a CRC error gives 4.
- R6: Error tags ERRA (`rx_tag`=2) and ERRC (`rx_tag`=3) end the transaction with status 2 and send no poll.
- R7: A receiver timeout gives status 3 and a CRC error gives status 4, whatever the tag. A timeout takes precedence over a CRC error.
- R8: After the final reply of each transaction, PRIME_CYC idle-high line cycles are driven before `stat_vld`.
- R9: A break request on link 0 drives PRE_BRK_CYC cycles high, BRK_CYC cycles low, ECHO_CYC cycles high and POST_BRK_CYC cycles high, in that order. It sends no command and then reports status 0.
- R10: A request whose `req_link` is not 0 reports status 5 (rejected) in the next cycle, with no line activity and no command.
- R11: Requests are ignored while `busy` is 1. `busy` falls in the cycle after `stat_vld`.
- R12: `stat_vld` is a one-cycle pulse. `rdata` is 0 unless the status is 0 and the request was a read. If several request inputs are high together, break wins over write, and write wins over read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one line clock per cycle while `ln_en` is high |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_rd | input | 1 | Read request |
| req_wr | input | 1 | Write request |
| req_brk | input | 1 | Line-reset (break) request |
| req_link | input | 2 | Target link; only 0 is served |
| req_slave | input | 2 | Slave identifier |
| req_addr | input | ADDR_W | Access address |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Transaction in progress; requests ignored |
| stat_vld | output | 1 | One-cycle status strobe |
| stat | output | 3 | 0 OK, 1 stuck busy, 2 error tag, 3 timeout, 4 CRC, 5 rejected |
| rdata | output | DATA_W | Read data, valid with `stat_vld` |
| tx_go | output | 1 | Start pulse to the frame transmitter |
| tx_kind | output | 2 | 0 access, 1 poll, 2 terminate |
| tx_slave | output | 2 | Slave identifier for the command |
| tx_addr | output | ADDR_W | Access address |
| tx_wr | output | 1 | Access is a write |
| tx_size | output | 3 | Access size in bytes |
| tx_wdata | output | DATA_W | Write payload |
| tx_done | input | 1 | Transmitter finished the command |
| rx_go | output | 1 | Start pulse to the response receiver |
| rx_bytes | output | 3 | Data bytes expected in the reply |
| rx_done | input | 1 | Reply captured |
| rx_tag | input | 2 | Reply tag: 0 ACK, 1 BUSY, 2 ERRA, 3 ERRC |
| rx_data | input | DATA_W | Reply data |
| rx_tmo | input | 1 | Receiver gave up waiting for a start bit |
| rx_crc | input | 1 | Reply failed its CRC check |
| ln_en | output | 1 | Sequencer clocks and owns the line this cycle |
| ln_dat | output | 1 | Line level while `ln_en` is high (1 = idle) |

## Verification
The bench builds the block with short runs: INIT 7, pre-break 3, break 4, echo 2, post-break 6 and prime 5 cycles. This lets it count every idle and break run exactly, cycle by cycle. POLL_IDLE is set to 8, below the safe floor, so the bench can confirm that the poll gap is still 21 cycles. BUSY_MAX is 2, so the bench reaches both the last allowed poll and the escalation to terminate within a few replies. With that setting, every kind of terminate reply can be tried.

// File: rtl/bus_txn_seq_pkg.sv
package bus_txn_seq_pkg;

    typedef enum logic [1:0] {
        CMD_ACCESS = 2'd0,
        CMD_POLL   = 2'd1,
        CMD_TERM   = 2'd2
    } cmd_e;

    typedef enum logic [2:0] {
        ST_OK     = 3'd0,
        ST_STUCK  = 3'd1,
        ST_ERRTAG = 3'd2,
        ST_TMO    = 3'd3,
        ST_CRC    = 3'd4,
        ST_REJECT = 3'd5
    } stat_e;

    localparam logic [1:0] TAG_ACK  = 2'd0;
    localparam logic [1:0] TAG_BUSY = 2'd1;

    localparam int POLL_FLOOR = 21;

    typedef enum logic [3:0] {
        S_INIT, S_IDLE, S_SEND, S_TXW, S_ECHO, S_RXGO, S_RXW,
        S_GAP, S_PRIME, S_BPRE, S_BLOW, S_BECHO, S_BPOST, S_DONE
    } state_e;

endpackage

// File: rtl/seq_run_cnt.sv
module seq_run_cnt #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (ld)
            cnt_d = ld_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= W'(RST_VAL);
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/seq_outcome.sv
module seq_outcome
    import bus_txn_seq_pkg::*;
(
    input  logic       tmo,
    input  logic       crc,
    input  logic [1:0] tag,
    input  logic       term_ph,
    output stat_e      stat,
    output logic       retry
);
    always_comb begin
        retry = 1'b0;
        if (tmo)
            stat = ST_TMO;
        else if (crc)
            stat = ST_CRC;
        else if (tag == TAG_ACK)
            stat = term_ph ? ST_STUCK : ST_OK;
        else begin
            stat  = ST_ERRTAG;
            retry = (tag == TAG_BUSY) && !term_ph;
        end
    end
endmodule

// File: rtl/bus_txn_sequencer.sv
module bus_txn_sequencer
    import bus_txn_seq_pkg::*;
#(
    parameter int ADDR_W       = 21,
    parameter int DATA_W       = 32,
    parameter int BUSY_MAX     = 100,
    parameter int POLL_IDLE    = 100,
    parameter int PRIME_CYC    = 100,
    parameter int ECHO_CYC     = 16,
    parameter int PRE_BRK_CYC  = 50,
    parameter int BRK_CYC      = 256,
    parameter int POST_BRK_CYC = 16000,
    parameter int INIT_CYC     = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic              req_brk,
    input  logic [1:0]        req_link,
    input  logic [1:0]        req_slave,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              stat_vld,
    output logic [2:0]        stat,
    output logic [DATA_W-1:0] rdata,
    output logic              tx_go,
    output logic [1:0]        tx_kind,
    output logic [1:0]        tx_slave,
    output logic [ADDR_W-1:0] tx_addr,
    output logic              tx_wr,
    output logic [2:0]        tx_size,
    output logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_done,
    output logic              rx_go,
    output logic [2:0]        rx_bytes,
    input  logic              rx_done,
    input  logic [1:0]        rx_tag,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_tmo,
    input  logic              rx_crc,
    output logic              ln_en,
    output logic              ln_dat
);
    localparam int GAP_CYC = (POLL_IDLE < POLL_FLOOR) ? POLL_FLOOR : POLL_IDLE;

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    localparam int MAX_RUN = max2(max2(max2(INIT_CYC, POST_BRK_CYC), max2(BRK_CYC, PRE_BRK_CYC)),
                                  max2(max2(ECHO_CYC, PRIME_CYC), GAP_CYC));
    localparam int CW = $clog2(MAX_RUN + 1);
    localparam int TW = $clog2(BUSY_MAX + 1);

    typedef struct packed {
        state_e              st;
        logic [TW-1:0]       tries;
        logic                term_ph;
        cmd_e                cmd;
        logic                rd;
        logic                wr;
        logic [1:0]          slave;
        logic [ADDR_W-1:0]   addr;
        logic [2:0]          size;
        logic [DATA_W-1:0]   wdata;
        stat_e               stat;
        logic [DATA_W-1:0]   rdata;
    } seq_t;

    seq_t          q, d;
    logic          cnt_ld;
    logic [CW-1:0] cnt_val;
    logic          cnt_zero;
    stat_e         oc_stat;
    logic          oc_retry;

    seq_run_cnt #(.W(CW), .RST_VAL(INIT_CYC - 1)) i_run (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (cnt_ld),
        .ld_val (cnt_val),
        .zero   (cnt_zero)
    );

    seq_outcome i_oc (
        .tmo     (rx_tmo),
        .crc     (rx_crc),
        .tag     (rx_tag),
        .term_ph (q.term_ph),
        .stat    (oc_stat),
        .retry   (oc_retry)
    );

    always_comb begin
        d       = q;
        cnt_ld  = 1'b0;
        cnt_val = '0;
        unique case (q.st)
            S_INIT: if (cnt_zero) d.st = S_IDLE;
            S_IDLE: begin
                if (req_brk || req_wr || req_rd) begin
                    d.tries   = '0;
                    d.term_ph = 1'b0;
                    d.cmd     = CMD_ACCESS;
                    d.rd      = !req_brk && !req_wr;
                    d.wr      = !req_brk && req_wr;
                    d.slave   = req_slave;
                    d.addr    = req_addr;
                    d.size    = req_size;
                    d.wdata   = req_wdata;
                    d.rdata   = '0;
                    d.stat    = ST_OK;
                    if (req_link != 2'd0) begin
                        d.stat = ST_REJECT;
                        d.st   = S_DONE;
                    end else if (req_brk) begin
                        d.st    = S_BPRE;
                        cnt_ld  = 1'b1;
                        cnt_val = CW'(PRE_BRK_CYC - 1);
                    end else begin
                        d.st = S_SEND;
                    end
                end
            end
            S_SEND: d.st = S_TXW;
            S_TXW: if (tx_done) begin
                d.st    = S_ECHO;
                cnt_ld  = 1'b1;
                cnt_val = CW'(ECHO_CYC - 1);
            end
            S_ECHO: if (cnt_zero) d.st = S_RXGO;
            S_RXGO: d.st = S_RXW;
            S_RXW: if (rx_done) begin
                cnt_ld = 1'b1;
                if (oc_retry) begin
                    d.st    = S_GAP;
                    cnt_val = CW'(GAP_CYC - 1);
                end else begin
                    d.st    = S_PRIME;
                    cnt_val = CW'(PRIME_CYC - 1);
                    d.stat  = oc_stat;
                    if (oc_stat == ST_OK && q.rd) d.rdata = rx_data;
                end
            end
            S_GAP: if (cnt_zero) begin
                d.st = S_SEND;
                if (q.tries < TW'(BUSY_MAX)) begin
                    d.tries = q.tries + 1'b1;
                    d.cmd   = CMD_POLL;
                end else begin
                    d.term_ph = 1'b1;
                    d.cmd     = CMD_TERM;
                end
            end
            S_PRIME: if (cnt_zero) d.st = S_DONE;
            S_BPRE: if (cnt_zero) begin
                d.st    = S_BLOW;
                cnt_ld  = 1'b1;
                cnt_val = CW'(BRK_CYC - 1);
            end
            S_BLOW: if (cnt_zero) begin
                d.st    = S_BECHO;
                cnt_ld  = 1'b1;
                cnt_val = CW'(ECHO_CYC - 1);
            end
            S_BECHO: if (cnt_zero) begin
                d.st    = S_BPOST;
                cnt_ld  = 1'b1;
                cnt_val = CW'(POST_BRK_CYC - 1);
            end
            S_BPOST: if (cnt_zero) d.st = S_DONE;
            S_DONE: d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_INIT;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.st != S_IDLE);
    assign stat_vld = (q.st == S_DONE);
    assign stat     = q.stat;
    assign rdata    = q.rdata;
    assign tx_go    = (q.st == S_SEND);
    assign tx_kind  = q.cmd;
    assign tx_slave = q.slave;
    assign tx_addr  = q.addr;
    assign tx_wr    = q.wr;
    assign tx_size  = q.size;
    assign tx_wdata = q.wdata;
    assign rx_go    = (q.st == S_RXGO);
    assign rx_bytes = (q.rd && q.cmd != CMD_TERM) ? q.size : 3'd0;
    assign ln_en    = (q.st inside {S_INIT, S_ECHO, S_GAP, S_PRIME,
                                    S_BPRE, S_BLOW, S_BECHO, S_BPOST});
    assign ln_dat   = (q.st != S_BLOW);
endmodule

// File: rtl/bus_txn_seq_chk.sv
module bus_txn_seq_chk
    import bus_txn_seq_pkg::*;
#(
    parameter int ECHO_CYC = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_rd,
    input logic       req_wr,
    input logic       req_brk,
    input logic [1:0] req_link,
    input logic       busy,
    input logic       stat_vld,
    input logic [2:0] stat,
    input logic       tx_go,
    input logic [1:0] tx_kind,
    input logic       rx_go,
    input logic       ln_en,
    input logic       ln_dat
);
    logic [31:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     run_q <= '0;
        else if (ln_en) run_q <= run_q + 1;
        else            run_q <= '0;
    end

    // R10
    link_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (req_rd || req_wr || req_brk) && req_link != 2'd0)
        |=> (stat_vld && stat == 3'(ST_REJECT)));

    // R11
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld |=> !busy);

    // R12
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld |=> !stat_vld);

    // R2
    tx_owns_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_go |-> (!ln_en && !rx_go));

    // R2
    echo_before_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_go |-> (run_q == 32'(ECHO_CYC)));

    // R3
    poll_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_go && tx_kind != 2'(CMD_ACCESS)) |-> (run_q >= 32'(POLL_FLOOR)));

    // R9
    low_follows_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ln_dat) |-> ($past(ln_en) && ln_en));
endmodule

bind bus_txn_sequencer bus_txn_seq_chk #(.ECHO_CYC(ECHO_CYC)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_rd   (req_rd),
    .req_wr   (req_wr),
    .req_brk  (req_brk),
    .req_link (req_link),
    .busy     (busy),
    .stat_vld (stat_vld),
    .stat     (stat),
    .tx_go    (tx_go),
    .tx_kind  (tx_kind),
    .rx_go    (rx_go),
    .ln_en    (ln_en),
    .ln_dat   (ln_dat)
);

// File: tb/test_bus_txn_sequencer.sv
module test_bus_txn_sequencer;
    localparam int AW = 21, DW = 32;
    localparam int BMAX = 2, PIDLE = 8, GAP = 21, PRIME = 5, ECHO = 2;
    localparam int PRE = 3, BRK = 4, POST = 6, INIT = 7;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_rd = 0, req_wr = 0, req_brk = 0;
    logic [1:0] req_link = 0, req_slave = 0;
    logic [AW-1:0] req_addr = 0;
    logic [2:0] req_size = 0;
    logic [DW-1:0] req_wdata = 0;
    logic busy, stat_vld, tx_go, tx_wr, rx_go, ln_en, ln_dat;
    logic [2:0] stat, tx_size, rx_bytes;
    logic [DW-1:0] rdata, tx_wdata;
    logic [1:0] tx_kind, tx_slave;
    logic [AW-1:0] tx_addr;
    logic tx_done = 0, rx_done = 0, rx_tmo = 0, rx_crc = 0;
    logic [1:0] rx_tag = 0;
    logic [DW-1:0] rx_data = 0;

    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    bus_txn_sequencer #(
        .ADDR_W(AW), .DATA_W(DW), .BUSY_MAX(BMAX), .POLL_IDLE(PIDLE),
        .PRIME_CYC(PRIME), .ECHO_CYC(ECHO), .PRE_BRK_CYC(PRE), .BRK_CYC(BRK),
        .POST_BRK_CYC(POST), .INIT_CYC(INIT)
    ) i_bus_txn_sequencer (
        .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr), .req_brk(req_brk),
        .req_link(req_link), .req_slave(req_slave), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .busy(busy), .stat_vld(stat_vld), .stat(stat), .rdata(rdata),
        .tx_go(tx_go), .tx_kind(tx_kind), .tx_slave(tx_slave), .tx_addr(tx_addr), .tx_wr(tx_wr),
        .tx_size(tx_size), .tx_wdata(tx_wdata), .tx_done(tx_done), .rx_go(rx_go),
        .rx_bytes(rx_bytes), .rx_done(rx_done), .rx_tag(rx_tag), .rx_data(rx_data),
        .rx_tmo(rx_tmo), .rx_crc(rx_crc), .ln_en(ln_en), .ln_dat(ln_dat)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // op(2) link(2) nbusy(4) tag(2) tmo(1) crc(1) expected status(3)
    // op: 0 read, 1 write, 2 break
    localparam int NV = 17;
    localparam logic [14:0] VECS [NV] = '{
        {2'd0, 2'd0, 4'd0, 2'd0, 1'b0, 1'b0, 3'd0},  // R2 read ack
        {2'd1, 2'd0, 4'd0, 2'd0, 1'b0, 1'b0, 3'd0},  // R2 write ack
        {2'd0, 2'd0, 4'd1, 2'd0, 1'b0, 1'b0, 3'd0},  // R3 one busy
        {2'd1, 2'd0, 4'd2, 2'd0, 1'b0, 1'b0, 3'd0},  // R3 last allowed poll
        {2'd0, 2'd0, 4'd3, 2'd0, 1'b0, 1'b0, 3'd1},  // R4 term ack
        {2'd1, 2'd0, 4'd3, 2'd2, 1'b0, 1'b0, 3'd2},  // R5 term erra
        {2'd0, 2'd0, 4'd3, 2'd0, 1'b1, 1'b0, 3'd3},  // R5 term timeout
        {2'd0, 2'd0, 4'd3, 2'd1, 1'b0, 1'b0, 3'd2},  // R5 term busy
        {2'd0, 2'd0, 4'd0, 2'd2, 1'b0, 1'b0, 3'd2},  // R6 erra
        {2'd1, 2'd0, 4'd0, 2'd3, 1'b0, 1'b0, 3'd2},  // R6 errc
        {2'd0, 2'd0, 4'd0, 2'd0, 1'b1, 1'b0, 3'd3},  // R7 timeout
        {2'd0, 2'd0, 4'd0, 2'd1, 1'b0, 1'b1, 3'd4},  // R7 crc beats busy tag
        {2'd0, 2'd0, 4'd0, 2'd0, 1'b1, 1'b1, 3'd3},  // R7 timeout beats crc
        {2'd0, 2'd0, 4'd1, 2'd0, 1'b0, 1'b1, 3'd4},  // R7 crc after a poll
        {2'd2, 2'd0, 4'd0, 2'd0, 1'b0, 1'b0, 3'd0},  // R9 break
        {2'd0, 2'd1, 4'd0, 2'd0, 1'b0, 1'b0, 3'd5},  // R10 read link 1
        {2'd2, 2'd2, 4'd0, 2'd0, 1'b0, 1'b0, 3'd5}   // R10 break link 2
    };

    task automatic run_txn(int op, int link, int nbusy, int ftag, int ftmo, int fcrc,
                           int exp_st, logic [DW-1:0] dat, int poke);
        int run = 0, txd = 0, rxd = 0, rsp = 0, guard = 0;
        int npoll = 0, nterm = 0, nacc = 0, hi = 0, lo = 0, nvld = 0;
        int last_kind = 0;
        logic fin = 0;
        int exp_poll, exp_term;
        @(negedge clk);
        req_rd   = (op == 0);
        req_wr   = (op == 1);
        req_brk  = (op == 2);
        req_link = link[1:0];
        req_slave = 2'd2;
        req_addr = 21'h0ABCD + AW'(op);
        req_size = 3'd4;
        req_wdata = dat ^ 32'hFFFF_0000;
        while (!fin && guard < 3000) begin
            @(negedge clk);
            guard++;
            req_rd = 0; req_wr = 0; req_brk = 0;
            tx_done = 0; rx_done = 0;
            if (poke != 0 && guard == 4) begin
                req_wr = 1; req_link = 2'd1;   // R11 must be ignored while busy
            end
            if (nvld > 0) begin
                check("R12 vld one cycle", int'(stat_vld), 0);
                check("R11 busy clears", int'(busy), 0);
                fin = 1;
            end else begin
                if (tx_go) begin
                    last_kind = int'(tx_kind);
                    if (tx_kind == 2'd0) begin
                        nacc++;
                        check("R2 tx_wr", int'(tx_wr), int'(op == 1));
                        check("R2 tx_addr", int'(tx_addr), int'(21'h0ABCD + AW'(op)));
                        check("R2 tx_slave", int'(tx_slave), 2);
                    end else begin
                        if (tx_kind == 2'd1) npoll++; else nterm++;
                        check("R3 gap length", run, GAP);
                    end
                    txd = 3;
                end else if (txd > 0) begin
                    txd--;
                    if (txd == 0) tx_done = 1;
                end
                if (rx_go) begin
                    check("R2 echo run", run, ECHO);
                    check("R2 rx_bytes", int'(rx_bytes), (op == 0 && last_kind != 2) ? 4 : 0);
                    rxd = 2;
                end else if (rxd > 0) begin
                    rxd--;
                    if (rxd == 0) begin
                        rx_done = 1;
                        rx_data = dat;
                        if (rsp < nbusy) begin
                            rx_tag = 2'd1; rx_tmo = 0; rx_crc = 0;
                        end else begin
                            rx_tag = ftag[1:0]; rx_tmo = ftmo[0]; rx_crc = fcrc[0];
                        end
                        rsp++;
                    end
                end
                if (ln_en) begin
                    if (ln_dat) hi++; else lo++;
                end
                if (stat_vld) begin
                    nvld++;
                    check("R2-status", int'(stat), exp_st);
                    check("R12 rdata", int'(rdata),
                          (exp_st == 0 && op == 0 && link == 0) ? int'(dat) : 0);
                    if (link == 0 && op != 2) check("R8 prime run", run, PRIME);
                end
            end
            run = ln_en ? run + 1 : 0;
        end
        check("R12 txn ended", int'(fin), 1);
        if (link != 0) begin
            check("R10 no line activity", hi + lo, 0);
            check("R10 no command", nacc + npoll + nterm, 0);
        end else if (op == 2) begin
            check("R9 low cycles", lo, BRK);
            check("R9 high cycles", hi, PRE + ECHO + POST);
            check("R9 no command", nacc, 0);
        end else begin
            exp_poll = (nbusy < BMAX) ? nbusy : BMAX;
            exp_term = (nbusy > BMAX) ? 1 : 0;
            check("R3 poll count", npoll, exp_poll);
            check("R4 term count", nterm, exp_term);
            check("R8 idle total", hi, ECHO * (1 + exp_poll + exp_term)
                                       + GAP * (exp_poll + exp_term) + PRIME);
            check("R6 no low", lo, 0);
        end
        req_link = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cnt;
        logic [DW-1:0] dv;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy in reset", int'(busy), 1);
        check("R1 line en in reset", int'(ln_en), 1);
        check("R1 line high in reset", int'(ln_dat), 1);
        check("R1 no vld in reset", int'(stat_vld), 0);
        rst_n = 1'b1;
        cnt = ln_en ? 1 : 0;
        for (int g = 0; g < 100; g++) begin
            @(negedge clk);
            if (!busy) break;
            if (ln_en && ln_dat) cnt++;
            if (stat_vld) check("R1 no vld during init", 1, 0);
        end
        check("R1 init clocks", cnt, INIT);
        check("R1 busy falls", int'(busy), 0);

        for (int i = 0; i < NV; i++) begin
            dv = 32'h5A00_0000 ^ (32'(i) * 32'h0001_0203);
            run_txn(int'(VECS[i][14:13]), int'(VECS[i][12:11]), int'(VECS[i][10:7]),
                    int'(VECS[i][6:5]), int'(VECS[i][4]), int'(VECS[i][3]),
                    int'(VECS[i][2:0]), dv, 0);
        end

        // R11 request during a busy read is ignored
        run_txn(0, 0, 0, 0, 0, 0, 0, 32'h1234_5678, 1);
        // R12 break wins over read and write when all are high
        @(negedge clk);
        req_rd = 1; req_wr = 1; req_brk = 1; req_link = 0;
        @(negedge clk);
        req_rd = 0; req_wr = 0; req_brk = 0;
        check("R12 priority: break low line", int'(ln_en && !ln_dat) | int'(tx_go), 0);
        cnt = 0;
        for (int g = 0; g < 100; g++) begin
            if (ln_en && !ln_dat) cnt++;
            if (tx_go) check("R12 priority no command", 1, 0);
            if (stat_vld) break;
            @(negedge clk);
        end
        check("R12 priority break pattern", cnt, BRK);
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule